// File: doc/BRIEF.md
# Paired-Destination Register File

This block is the general-purpose register storage for a small 16-bit processor whose arithmetic instructions write their result back into the first source register. It has eight 16-bit registers and two read ports. Both read ports are combinational, so the two operand registers named by an instruction can be read in the same cycle. Each read port has its own index input.

There are two synchronous write ports. The primary port always writes the register selected by read index A, because the first source is also the destination. The secondary port always writes the next register up from that destination, wrapping from the last register to register 0. Instructions with a double-width or two-part result use the secondary port to place their second half beside the first in the same clock edge. A multiply sends its low half to the destination and its high half to the next register. A divide sends its quotient to the destination and its remainder to the next register.

The block has a synchronous reset that clears every register. A read returns the value held before the coming edge: a write in progress never shows on a read port in the same cycle.

Top module: `pairwr_regfile`

## Requirements
- R1: When `rst` is high at a rising clock edge, every register holds 0 after that edge, whatever the write enables and data are.
- R2: `rda_data` shows the register selected by `rda_idx` and `rdb_data` shows the register selected by `rdb_idx`. Both outputs follow their index combinationally and do not depend on each other.
- R3: When `pwr_en` is high at a rising edge and `rst` is low, the register selected by `rda_idx` takes `pwr_data`.
- R4: When `swr_en` is high at a rising edge and `rst` is low, the register numbered `rda_idx`+1 takes `swr_data`.
- R5: The secondary index wraps modulo the register count. With `rda_idx` = 7, a secondary write goes to register 0.
- R6: With both enables high, the destination takes `pwr_data` and the next register takes `swr_data` at the same edge. An example is a multiply low/high pair or a divide quotient/remainder pair.
- R7: There is no write-through. While a write to a register is pending, a read of that register returns the value held before the edge.
- R8: With both enables low and `rst` low, no register changes at the edge, whatever is on the data inputs.
- R9: A write changes only its target register or registers. Every other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All register updates happen on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. Clears every register. |
| rda_idx | input | 3 | Index of the first source register. It is also the primary write destination. |
| rdb_idx | input | 3 | Index of the second source register. |
| rda_data | output | 16 | Contents of the register at `rda_idx`. |
| rdb_data | output | 16 | Contents of the register at `rdb_idx`. |
| pwr_en | input | 1 | Primary write enable. |
| pwr_data | input | 16 | Primary write data: a result, a multiply low half or a divide quotient. |
| swr_en | input | 1 | Secondary write enable, for the register after the destination. |
| swr_data | input | 16 | Secondary write data: a multiply high half or a divide remainder. |

## Verification
A register that holds a wrong value shows it on any read port addressed to that register, right after the edge that corrupted it, because the read path has no register. Writes that go to the wrong target are found by a full readback. The bench reads every register after each directed phase and after each random operation. A misdirected write therefore appears as a mismatch at a register that should not have changed, or at the one that should have, within one cycle. A write-through fault shows up before the edge, in the pre-edge sample taken during every write cycle.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    // Per-register next-value selection.
    typedef enum logic [1:0] {
        WSEL_HOLD  = 2'd0,
        WSEL_SEC   = 2'd1,
        WSEL_PRI   = 2'd2,
        WSEL_CLEAR = 2'd3
    } wsel_e;

    // Secondary target: one above the destination, wrapping at the count.
    function automatic int unsigned next_index(input int unsigned idx, input int unsigned count);
        return (idx + 1 >= count) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rfx_onehot.sv
module rfx_onehot #(
    parameter int N    = 8,
    parameter int IW   = 3
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  mask
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign mask[g] = en && (idx == IW'(g));
    end

endmodule

// File: rtl/rfx_word.sv
module rfx_word
    import rfx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pri_hit,
    input  logic         sec_hit,
    input  logic [W-1:0] pri_data,
    input  logic [W-1:0] sec_data,
    output logic [W-1:0] q
);

    wsel_e sel;

    // Reset first, then the primary port over the secondary port.
    always_comb begin
        if (rst)          sel = WSEL_CLEAR;
        else if (pri_hit) sel = WSEL_PRI;
        else if (sec_hit) sel = WSEL_SEC;
        else              sel = WSEL_HOLD;
    end

    always_ff @(posedge clk) begin
        unique case (sel)
            WSEL_CLEAR: q <= '0;
            WSEL_PRI:   q <= pri_data;
            WSEL_SEC:   q <= sec_data;
            WSEL_HOLD:  q <= q;
        endcase
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!pri_hit && !sec_hit) |=> $stable(q)); // R8
    AST_PRI_LOADS: assert property (@(posedge clk) disable iff (rst)
        pri_hit |=> (q == $past(pri_data))); // R3
    AST_SEC_LOADS: assert property (@(posedge clk) disable iff (rst)
        (sec_hit && !pri_hit) |=> (q == $past(sec_data))); // R4

endmodule

// File: rtl/rfx_rdport.sv
module rfx_rdport #(
    parameter int N  = 8,
    parameter int W  = 16,
    parameter int IW = 3
) (
    input  logic [W-1:0]  words [N],
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  data
);

    always_comb begin
        data = '0;
        for (int k = 0; k < N; k++) begin
            if (idx == IW'(k)) data = words[k];
        end
    end

endmodule

// File: rtl/pairwr_regfile.sv
module pairwr_regfile
    import rfx_pkg::*;
#(
    parameter  int NUM_REGS = 8,
    parameter  int WIDTH    = 16,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rda_idx,
    input  logic [IDX_W-1:0] rdb_idx,
    output logic [WIDTH-1:0] rda_data,
    output logic [WIDTH-1:0] rdb_data,
    input  logic             pwr_en,
    input  logic [WIDTH-1:0] pwr_data,
    input  logic             swr_en,
    input  logic [WIDTH-1:0] swr_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    logic [IDX_W-1:0]    sec_idx;
    logic [NUM_REGS-1:0] pri_mask;
    logic [NUM_REGS-1:0] sec_mask;
    logic [WIDTH-1:0]    store [NUM_REGS];

    // Secondary target index, modulo the register count.
    assign sec_idx = IDX_W'(next_index(int'(rda_idx), NUM_REGS));

    rfx_onehot #(.N(NUM_REGS), .IW(IDX_W)) u_pri_dec (
        .en   (pwr_en),
        .idx  (rda_idx),
        .mask (pri_mask)
    );

    rfx_onehot #(.N(NUM_REGS), .IW(IDX_W)) u_sec_dec (
        .en   (swr_en),
        .idx  (sec_idx),
        .mask (sec_mask)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        rfx_word #(.W(WIDTH)) u_word (
            .clk      (clk),
            .rst      (rst),
            .pri_hit  (pri_mask[g]),
            .sec_hit  (sec_mask[g]),
            .pri_data (pwr_data),
            .sec_data (swr_data),
            .q        (store[g])
        );
    end

    rfx_rdport #(.N(NUM_REGS), .W(WIDTH), .IW(IDX_W)) u_rd_a (
        .words (store),
        .idx   (rda_idx),
        .data  (rda_data)
    );

    rfx_rdport #(.N(NUM_REGS), .W(WIDTH), .IW(IDX_W)) u_rd_b (
        .words (store),
        .idx   (rdb_idx),
        .data  (rdb_data)
    );

    AST_ONE_HIT_EACH: assert property (@(posedge clk) disable iff (rst)
        ($onehot0(pri_mask) && $onehot0(sec_mask))); // R9
    AST_PAIR_APART: assert property (@(posedge clk) disable iff (rst)
        (NUM_REGS < 2) || ($countones(pri_mask & sec_mask) == 0)); // R6
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (swr_en && rda_idx == LAST_IDX && NUM_REGS > 1) |=> (store[0] == $past(swr_data))); // R5

endmodule

// File: tb/pairwr_regfile_test.sv
module pairwr_regfile_test;

    localparam int N = 8;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [2:0]   rda_idx, rdb_idx;
    logic [W-1:0] rda_data, rdb_data;
    logic         pwr_en, swr_en;
    logic [W-1:0] pwr_data, swr_data;

    logic [W-1:0] model [N];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pairwr_regfile uut (
        .clk(clk), .rst(rst),
        .rda_idx(rda_idx), .rdb_idx(rdb_idx),
        .rda_data(rda_data), .rdb_data(rdb_data),
        .pwr_en(pwr_en), .pwr_data(pwr_data),
        .swr_en(swr_en), .swr_data(swr_data)
    );

    function automatic int nxt(input int i);
        return (i + 1) % N;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check the reads before the
    // rising edge, then update the model after that edge.
    task automatic cycle(input bit r, input int a, input int b,
                         input bit pe, input logic [W-1:0] pd,
                         input bit se, input logic [W-1:0] sd);
        @(negedge clk);
        rst = r; rda_idx = 3'(a); rdb_idx = 3'(b);
        pwr_en = pe; pwr_data = pd; swr_en = se; swr_data = sd;
        #1;
        if (!r) begin
            // R7: the values seen before the edge are the old contents.
            check(rda_data == model[a], (pe || se) ? "R7 port A" : "R2 port A", rda_data, model[a]);
            check(rdb_data == model[b], (pe || se) ? "R7 port B" : "R2 port B", rdb_data, model[b]);
        end
        @(posedge clk);
        if (r) begin
            for (int k = 0; k < N; k++) model[k] = '0;
        end else begin
            if (se) model[nxt(a)] = sd;
            if (pe) model[a] = pd;
        end
    endtask

    task automatic readback(input string tag);
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            rst = 1'b0; pwr_en = 1'b0; swr_en = 1'b0;
            pwr_data = 16'(k * 16'h1111); swr_data = ~pwr_data;
            rda_idx = 3'(k); rdb_idx = 3'(N - 1 - k);
            #1;
            check(rda_data == model[k], tag, rda_data, model[k]);
            check(rdb_data == model[N - 1 - k], tag, rdb_data, model[N - 1 - k]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < N; k++) model[k] = 16'hxxxx;
        rst = 1'b1; rda_idx = '0; rdb_idx = '0;
        pwr_en = 1'b0; swr_en = 1'b0; pwr_data = '0; swr_data = '0;
        cycle(1'b1, 0, 0, 1'b1, 16'hdead, 1'b1, 16'hbeef);
        cycle(1'b1, 5, 2, 1'b0, 16'h0, 1'b0, 16'h0);
        readback("R1 reset state");

        // R3 and R9: fill each register through the primary port.
        for (int k = 0; k < N; k++)
            cycle(1'b0, k, (k + 3) % N, 1'b1, 16'(16'hA000 + k * 16'h0101), 1'b0, 16'hffff);
        readback("R3 primary fill");

        // R6 and R4: a product pair at register 3, a division pair at register 1.
        cycle(1'b0, 3, 4, 1'b1, 16'h5678, 1'b1, 16'h1234);
        readback("R6 product pair");
        cycle(1'b0, 1, 2, 1'b1, 16'h0007, 1'b1, 16'h0002);
        readback("R4 quotient remainder");

        // R5: a secondary write from register 7 wraps to register 0.
        cycle(1'b0, 7, 0, 1'b1, 16'h7777, 1'b1, 16'h0c0c);
        readback("R5 wrap");
        cycle(1'b0, 7, 0, 1'b0, 16'h1111, 1'b1, 16'h0d0d);
        readback("R5 wrap secondary only");

        // R8: the enables are low and the data toggles.
        for (int k = 0; k < 6; k++)
            cycle(1'b0, k, 7 - k, 1'b0, 16'($urandom), 1'b0, 16'($urandom));
        readback("R8 idle");

        // R7: a read and a write hit the same register in one cycle.
        cycle(1'b0, 2, 2, 1'b1, 16'h4242, 1'b0, 16'h0);
        cycle(1'b0, 2, 3, 1'b1, 16'h4343, 1'b1, 16'h9999);
        readback("R7 after write");

        // Random operation mix, with a readback after each operation (R9).
        for (int n = 0; n < 300; n++) begin
            int a, b;
            bit pe, se;
            a  = int'($urandom % N);
            b  = int'($urandom % N);
            pe = ($urandom % 4) != 0;
            se = ($urandom % 3) == 0;
            if (n % 10 == 0) a = N - 1;
            cycle(1'b0, a, b, pe, 16'($urandom), se, 16'($urandom));
            readback("R9 random");
        end

        // R1: a reset in the middle of the run overrides pending writes.
        cycle(1'b1, 4, 6, 1'b1, 16'hface, 1'b1, 16'hcafe);
        readback("R1 mid-run reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule